// File: doc/BRIEF.md
# Extraction Stream In-Band Status Encoder

This block sits between a switch's extraction queues and a CPU that polls them word by word. Each group accepts queue entries over a valid/ready handshake. An entry is a 32-bit data word plus sidebands: last-of-frame, valid-byte count, pruned and abort. The CPU sees one read-data value per group, and every read strobe consumes whatever that value currently is. No separate status register exists. Frame boundaries, byte counts, pruned and aborted frames, and the empty condition are all reported as reserved 32-bit words inside the read stream.

The reserved words all have bits [31:27] = 0 and bits [23:0] = 0x000080. Bits [26:24] then select one of eight meanings. A data word that happens to equal any of those eight values is sent behind an escape word, so the CPU takes the next word as literal data. A mode input chooses where the end-of-frame word goes: after the final data word, or in front of it. Each group also has a data-present flag and a flush input. The flush input discards everything queued in that group and everything offered to it while it is held.

Top module: `xtr_status_encoder`

## Requirements
- R1: While a group holds no entry, or while its flush input is high, its read data is 0x07000080 (not ready). A read strobe in that state changes nothing.
- R2: Data words are returned in order. A word that equals one of the eight reserved values 0x00000080, 0x01000080 … 0x07000080 is returned as 0x06000080 (escape), and the word itself follows on the next read.
- R3: A final word with k valid bytes, given as q_nbytes_i = k-1, closes the frame with the word 0x0N000080, where N = 4-k. With mode_stat_first_i = 0, the final data word (escaped if needed) comes first and this status word follows it.
- R4: With mode_stat_first_i = 1, the end-of-frame status word is returned first. The final data word follows it, escaped if needed.
- R5: A final word flagged pruned closes the frame with 0x04000080 in place of the byte-count code. Its final word counts as 4 bytes.
- R6: An abort entry reads as the single word 0x05000080. The read after it returns the first word of the next frame.
- R7: data_present_o of a group is high exactly when that group holds at least one entry and is not flushing.
- R8: While flush_i of a group is high, that group's q_ready_o is high and all held and incoming entries are discarded. In the cycle after flush_i drops, data_present_o is low. Frames sent after that read back normally.
- R9: Groups are independent. Traffic and reads on one group leave the other group's flag and read data unchanged.
- R10: q_ready_o of a group goes low only when that group holds DEPTH entries and is not flushing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_stat_first_i | input | 1 | 1: end-of-frame status word before the final data word |
| flush_i | input | NUM_GRP | Per-group discard control |
| q_valid_i | input | NUM_GRP | Queue entry offered |
| q_ready_o | output | NUM_GRP | Group can accept an entry |
| q_data_i | input | 32*NUM_GRP | Entry data word, group g in bits [32g+31:32g] |
| q_last_i | input | NUM_GRP | Entry is the final word of its frame |
| q_nbytes_i | input | 2*NUM_GRP | Valid bytes minus one of a final word |
| q_pruned_i | input | NUM_GRP | Frame was pruned |
| q_abort_i | input | NUM_GRP | Entry marks an aborted frame; data ignored |
| rd_i | input | NUM_GRP | CPU read strobe, consumes the current read word |
| rd_data_o | output | 32*NUM_GRP | Current read word per group |
| data_present_o | output | NUM_GRP | Group holds at least one entry |

## Verification
The hardest states to reach from the ports are a full group under backpressure and a flush that arrives while entries are still held. The bench reaches them by turning off its reader, filling the group until q_ready_o drops, and only then raising flush_i. A reserved value on the final word is also hard to produce by chance, because the escape must land on the correct side of the status word in each mode. It is therefore driven on purpose in both modes, as are reserved values in the middle of a frame and a value one bit away from a reserved code.

// File: rtl/xtr_pkg.sv
package xtr_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [23:0] CODE_TAIL = 24'h000080;

  localparam logic [2:0] N_PRUNED = 3'd4;
  localparam logic [2:0] N_ABORT  = 3'd5;
  localparam logic [2:0] N_ESC    = 3'd6;
  localparam logic [2:0] N_NREADY = 3'd7;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic              last;
    logic [1:0]        nbm1;
    logic              pruned;
    logic              abort;
  } xtr_entry_t;

  localparam int unsigned ENTRY_W = $bits(xtr_entry_t);

  typedef enum logic [1:0] {
    PH_HEAD,  // nothing of head entry sent yet
    PH_LIT,   // escape sent, literal pending
    PH_STAT,  // data sent, trailing status pending
    PH_BODY   // leading status sent, data pending
  } phase_e;

  function automatic logic [WORD_W-1:0] code_word(input logic [2:0] n);
    return {5'b0, n, CODE_TAIL};
  endfunction
endpackage

// File: rtl/xtr_fifo.sv
module xtr_fifo #(
  parameter int unsigned W     = 37,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i && !clr_i) mem[wp] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr_i) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_i) wp <= nxt(wp);
      if (pop_i)  rp <= nxt(rp);
      unique case ({push_i, pop_i})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout_o  = mem[rp];
  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/xtr_esc_detect.sv
module xtr_esc_detect
  import xtr_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic              hit_o
);
  localparam int unsigned NCODES = 8;
  logic [NCODES-1:0] hits;

  for (genvar k = 0; k < NCODES; k++) begin : g_code
    assign hits[k] = (word_i == code_word(3'(k)));
  end

  assign hit_o = |hits;
endmodule

// File: rtl/xtr_grp_engine.sv
module xtr_grp_engine
  import xtr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stat_first_i,
  input  logic              flush_i,
  input  logic              empty_i,
  input  xtr_entry_t        head_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              pop_o
);
  phase_e     phase_q, adv_ph;
  logic       adv_pop, esc_hit;
  logic [2:0] eof_n;

  xtr_esc_detect i_esc (.word_i(head_i.data), .hit_o(esc_hit));

  // nbm1 = bytes-1, so code = 4-bytes = ~nbm1
  assign eof_n = head_i.pruned ? N_PRUNED : {1'b0, ~head_i.nbm1};

  always_comb begin
    rd_data_o = code_word(N_NREADY);
    adv_pop   = 1'b0;
    adv_ph    = phase_q;
    if (flush_i || empty_i) begin
      rd_data_o = code_word(N_NREADY);
    end else if (head_i.abort) begin
      rd_data_o = code_word(N_ABORT);
      adv_pop   = 1'b1;
    end else begin
      unique case (phase_q)
        PH_HEAD: begin
          if (head_i.last && stat_first_i) begin
            rd_data_o = code_word(eof_n);
            adv_ph    = PH_BODY;
          end else if (esc_hit) begin
            rd_data_o = code_word(N_ESC);
            adv_ph    = PH_LIT;
          end else begin
            rd_data_o = head_i.data;
            if (head_i.last) adv_ph = PH_STAT;
            else             adv_pop = 1'b1;
          end
        end
        PH_BODY: begin
          if (esc_hit) begin
            rd_data_o = code_word(N_ESC);
            adv_ph    = PH_LIT;
          end else begin
            rd_data_o = head_i.data;
            adv_pop   = 1'b1;
          end
        end
        PH_LIT: begin
          rd_data_o = head_i.data;
          if (head_i.last && !stat_first_i) adv_ph = PH_STAT;
          else                              adv_pop = 1'b1;
        end
        PH_STAT: begin
          rd_data_o = code_word(eof_n);
          adv_pop   = 1'b1;
        end
        default: rd_data_o = code_word(N_NREADY);
      endcase
    end
  end

  assign pop_o = rd_i && adv_pop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= PH_HEAD;
    else if (flush_i) phase_q <= PH_HEAD;
    else if (rd_i)    phase_q <= adv_pop ? PH_HEAD : adv_ph;
  end
endmodule

// File: rtl/xtr_status_encoder.sv
module xtr_status_encoder
  import xtr_pkg::*;
#(
  parameter int unsigned NUM_GRP = 2,
  parameter int unsigned DEPTH   = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      mode_stat_first_i,
  input  logic [NUM_GRP-1:0]        flush_i,
  input  logic [NUM_GRP-1:0]        q_valid_i,
  output logic [NUM_GRP-1:0]        q_ready_o,
  input  logic [WORD_W*NUM_GRP-1:0] q_data_i,
  input  logic [NUM_GRP-1:0]        q_last_i,
  input  logic [2*NUM_GRP-1:0]      q_nbytes_i,
  input  logic [NUM_GRP-1:0]        q_pruned_i,
  input  logic [NUM_GRP-1:0]        q_abort_i,
  input  logic [NUM_GRP-1:0]        rd_i,
  output logic [WORD_W*NUM_GRP-1:0] rd_data_o,
  output logic [NUM_GRP-1:0]        data_present_o
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    xtr_entry_t  in_e, head_e;
    logic [ENTRY_W-1:0] head_raw;
    logic empty, full, push, pop;

    assign in_e.data   = q_data_i[g*WORD_W +: WORD_W];
    assign in_e.last   = q_last_i[g];
    assign in_e.nbm1   = q_nbytes_i[2*g +: 2];
    assign in_e.pruned = q_pruned_i[g];
    assign in_e.abort  = q_abort_i[g];

    assign q_ready_o[g] = flush_i[g] || !full;
    assign push         = q_valid_i[g] && !full && !flush_i[g];
    assign head_e       = xtr_entry_t'(head_raw);

    xtr_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) i_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (flush_i[g]),
      .push_i  (push),
      .din_i   (in_e),
      .pop_i   (pop),
      .dout_o  (head_raw),
      .empty_o (empty),
      .full_o  (full)
    );

    xtr_grp_engine i_eng (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .stat_first_i (mode_stat_first_i),
      .flush_i      (flush_i[g]),
      .empty_i      (empty),
      .head_i       (head_e),
      .rd_i         (rd_i[g]),
      .rd_data_o    (rd_data_o[g*WORD_W +: WORD_W]),
      .pop_o        (pop)
    );

    assign data_present_o[g] = !empty && !flush_i[g];
  end
endmodule

// File: rtl/xtr_status_encoder_chk.sv
module xtr_status_encoder_chk
  import xtr_pkg::*;
#(
  parameter int unsigned NUM_GRP = 2
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_GRP-1:0]        flush_i,
  input logic [NUM_GRP-1:0]        q_ready_o,
  input logic [NUM_GRP-1:0]        rd_i,
  input logic [WORD_W*NUM_GRP-1:0] rd_data_o,
  input logic [NUM_GRP-1:0]        data_present_o
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
    // R1
    idle_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !data_present_o[g] |-> rd_data_o[g*WORD_W +: WORD_W] == code_word(N_NREADY));
    // R2
    esc_keeps_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i[g] && data_present_o[g] && rd_data_o[g*WORD_W +: WORD_W] == code_word(N_ESC))
      |=> (flush_i[g] || data_present_o[g]));
    // R8
    flush_accepts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i[g] |-> q_ready_o[g]);
    // R8
    flush_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(flush_i[g]) |-> !data_present_o[g]);
    // R10
    backpressure_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !q_ready_o[g] |-> data_present_o[g]);
  end
endmodule

bind xtr_status_encoder xtr_status_encoder_chk #(.NUM_GRP(NUM_GRP)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .flush_i        (flush_i),
  .q_ready_o      (q_ready_o),
  .rd_i           (rd_i),
  .rd_data_o      (rd_data_o),
  .data_present_o (data_present_o)
);

// File: tb/test_xtr_status_encoder.sv
`timescale 1ns/1ps
module test_xtr_status_encoder;
  localparam int G = 2;
  localparam logic [31:0] NR  = 32'h07000080;
  localparam logic [31:0] ESC = 32'h06000080;
  localparam logic [31:0] ABT = 32'h05000080;
  localparam logic [31:0] PRN = 32'h04000080;

  logic clk = 1'b0, rst_ni = 1'b0, mode = 1'b0;
  logic [G-1:0] flush = '0, q_valid = '0, q_ready, q_last = '0, q_pruned = '0, q_abort = '0;
  logic [G-1:0] rd0 = '0, rd1 = '0, present;
  logic [32*G-1:0] q_data = '0, rd_data;
  logic [2*G-1:0] q_nb = '0;
  logic [G-1:0] rd;
  assign rd = rd0 | rd1;

  always #2 clk = ~clk;

  xtr_status_encoder #(.NUM_GRP(G), .DEPTH(4)) i_xtr_status_encoder (
    .clk_i(clk), .rst_ni(rst_ni), .mode_stat_first_i(mode), .flush_i(flush),
    .q_valid_i(q_valid), .q_ready_o(q_ready), .q_data_i(q_data), .q_last_i(q_last),
    .q_nbytes_i(q_nb), .q_pruned_i(q_pruned), .q_abort_i(q_abort), .rd_i(rd),
    .rd_data_o(rd_data), .data_present_o(present));

  int n_chk = 0, n_fail = 0;
  bit rd_en = 1'b0;
  logic [31:0] exp_q[$];
  string req_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_res(input logic [31:0] w);
    return (w[31:27] == 5'd0) && (w[23:0] == 24'h000080);
  endfunction

  task automatic expect_w(input logic [31:0] w, input string req);
    exp_q.push_back(w);
    req_q.push_back(req);
  endtask

  task automatic push_entry(input int g, input logic [31:0] d, input bit last,
                            input int nb, input bit pruned, input bit abort);
    @(negedge clk);
    q_valid[g] = 1'b1; q_data[g*32 +: 32] = d; q_last[g] = last;
    q_nb[2*g +: 2] = 2'(nb - 1); q_pruned[g] = pruned; q_abort[g] = abort;
    while (!q_ready[g]) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    q_valid[g] = 1'b0;
  endtask

  // driver: scoreboard entries computed from the requirements
  task automatic send_word(input logic [31:0] d, input bit last, input int nb,
                           input bit pruned, input string req);
    logic [31:0] code;
    code = pruned ? PRN : {5'd0, 3'(4 - nb), 24'h000080};
    if (!last) begin
      if (is_res(d)) expect_w(ESC, req);
      expect_w(d, req);
    end else if (!mode) begin
      if (is_res(d)) expect_w(ESC, req);
      expect_w(d, req);
      expect_w(code, req);
    end else begin
      expect_w(code, req);
      if (is_res(d)) expect_w(ESC, req);
      expect_w(d, req);
    end
    push_entry(0, d, last, nb, pruned, 1'b0);
  endtask

  task automatic send_abort(input string req);
    expect_w(ABT, req);
    push_entry(0, 32'h0, 1'b0, 4, 1'b0, 1'b1);
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    if (rd_en && present[0]) begin
      if (exp_q.size() == 0) chk("R7 unexpected word", rd_data[31:0], NR);
      else begin
        string r;
        logic [31:0] e;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk(r, rd_data[31:0], e);
      end
      rd0[0] = 1'b1;
    end else rd0[0] = 1'b0;
  end

  task automatic drain(input string req);
    for (int i = 0; i < 400 && (exp_q.size() != 0 || present[0]); i++) @(negedge clk);
    chk({req, " drained"}, 32'(exp_q.size()), 32'd0);
    @(negedge clk);
    chk("R7 idle after frame", {31'd0, present[0]}, 32'd0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R7 reset present", {30'd0, present}, 32'd0);
    chk("R1 reset read word", rd_data[31:0], NR);
    chk("R10 reset ready", {30'd0, q_ready}, 32'h3);
    // R1: read when empty does nothing
    rd1[0] = 1'b1; @(negedge clk); rd1[0] = 1'b0; @(negedge clk);
    chk("R1 empty read", rd_data[31:0], NR);
    chk("R1 empty read present", {31'd0, present[0]}, 32'd0);

    rd_en = 1'b1;
    // R2 R3 plain frame, data then status
    send_word(32'h11111111, 0, 4, 0, "R2 plain");
    send_word(32'hA5A50000, 0, 4, 0, "R2 plain");
    send_word(32'hDEADBEEF, 1, 2, 0, "R3 eof 2 bytes");
    drain("R3");
    // R2 reserved data mid-frame and on last word
    send_word(32'h03000080, 0, 4, 0, "R2 escape eof3");
    send_word(32'h00000080, 0, 4, 0, "R2 escape eof0");
    send_word(32'h07000081, 0, 4, 0, "R2 near miss");
    send_word(32'h06000080, 1, 4, 0, "R3 escaped last");
    drain("R2");
    send_word(32'hBEEF0001, 1, 1, 0, "R3 eof 1 byte");
    drain("R3 b");
    // R4 status-first
    mode = 1'b1;
    send_word(32'h12345678, 0, 4, 0, "R4 body");
    send_word(32'h05000080, 1, 1, 0, "R4 status then escaped last");
    send_word(32'h0000FFFF, 1, 3, 0, "R4 status then last");
    drain("R4");
    send_word(32'h77777777, 1, 4, 1, "R5 pruned status first");
    drain("R5 a");
    mode = 1'b0;
    send_word(32'h01010101, 0, 4, 0, "R5 body");
    send_word(32'h02020202, 1, 4, 1, "R5 pruned");
    drain("R5 b");
    // R6 abort
    send_word(32'hABCD0000, 0, 4, 0, "R6 before abort");
    send_abort("R6 abort code");
    send_word(32'h0BADF00D, 1, 4, 0, "R6 next frame");
    drain("R6");

    // R10 backpressure, R8 flush
    rd_en = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) push_entry(0, 32'hF0000000 + i, 0, 4, 0, 0);
    @(negedge clk);
    chk("R10 full ready low", {31'd0, q_ready[0]}, 32'd0);
    chk("R7 full present", {31'd0, present[0]}, 32'd1);
    chk("R10 other group ready", {31'd0, q_ready[1]}, 32'd1);
    flush[0] = 1'b1;
    @(negedge clk);
    chk("R8 ready during flush", {31'd0, q_ready[0]}, 32'd1);
    chk("R1 flush read word", rd_data[31:0], NR);
    chk("R7 present during flush", {31'd0, present[0]}, 32'd0);
    flush[0] = 1'b0;
    @(negedge clk);
    chk("R8 empty after flush", {31'd0, present[0]}, 32'd0);
    chk("R8 read word after flush", rd_data[31:0], NR);
    rd_en = 1'b1;
    send_word(32'h5A5A5A5A, 1, 4, 0, "R8 frame after flush");
    drain("R8");

    // R9 group independence
    rd_en = 1'b0;
    push_entry(1, 32'hCAFEF00D, 1, 4, 0, 0);
    @(negedge clk);
    chk("R9 g1 present", {31'd0, present[1]}, 32'd1);
    chk("R9 g0 untouched", {31'd0, present[0]}, 32'd0);
    chk("R9 g0 word", rd_data[31:0], NR);
    chk("R9 g1 data", rd_data[63:32], 32'hCAFEF00D);
    rd1[1] = 1'b1; @(negedge clk);
    chk("R9 g1 eof", rd_data[63:32], 32'h00000080);
    @(negedge clk); rd1[1] = 1'b0;
    chk("R9 g1 empty", {31'd0, present[1]}, 32'd0);
    chk("R9 g1 not ready", rd_data[63:32], NR);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule